// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Host Access Sequencer

This block runs one programmed-I/O access at a time on a parallel ATA-style bus from the host side. A client offers a request: a read or write, a 3-bit register address, one of two chip selects, an 8-bit or 16-bit width, write data and a timing mode from 0 to 4. The block drives the address and chip-select lines, pulses the read or write strobe, and enables the data-bus driver for writes. For reads it returns the sampled bus word with a one-cycle completion pulse.

Each access has four phases: address setup, strobe assertion, post-strobe hold, and recovery. Their lengths in clocks come from a per-mode table of nanosecond minimums. The table is converted at elaboration time with the clock period, rounding up. The device can stretch the strobe by holding the ready line low. If it holds the line low for too long, a watchdog ends the access and flags an error. The ready line is taken to be synchronous to the block clock already.

Top module: `ata_pio_host`

## Requirements
- R1: While reset is low, and after it, with no request pending, `req_ready` is 1, both strobes are 1, `pio_cs_n` is 2'b11, `pio_dout_en` is 0 and `rsp_done` is 0.
- R2: After a request is accepted, the address and chip select are valid with both strobes negated for exactly 7, 5, 3, 3, 3 clocks in modes 0 to 4. This comes from 70/50/30/30/25 ns at 10 ns per clock.
- R3: If ready stays high, the strobe stays low for exactly 17, 13, 10, 8, 7 clocks in modes 0 to 4. Only one strobe is ever low: `pio_wr_n` for writes and `pio_rd_n` for reads.
- R4: The strobe is released only at a clock edge where `pio_ready` is sampled high and the minimum width has passed. If ready is raised during strobe cycle L (counting from 0), the width is max(minimum, L+1).
- R5: If `pio_ready` is sampled low on 1024 consecutive strobe clocks, the strobe is released after that 1024th clock. The access then completes with `rsp_err` = 1. After a normal completion, `rsp_err` = 0.
- R6: Read data is captured from `pio_din` at the last clock edge at which the read strobe is still low. `pio_dout_en` stays 0 throughout a read.
- R7: After the strobe is negated, the chip select, the address and (for writes) the driven data stay in place for max(1, 3/2/2/1/1) clocks on writes and 1 clock on reads. On writes, `pio_dout_en` is 1 and `pio_dout` is stable from the first setup clock to the end of that hold.
- R8: `req_ready` stays low for exactly max(C, S+W+max(H,R)) clocks. Here C = 60/39/24/18/12, R = 0/0/0/7/3, S and H are as above, and W is the actual strobe width.
- R9: In narrow mode (`req_wide` = 0), only bits 7:0 are used. Write data is driven with bits 15:8 at zero, and read data is returned with bits 15:8 at zero.
- R10: Mode values 5, 6 and 7 are timed as mode 0.
- R11: `rsp_done` is high for exactly one clock per access: the first clock after the strobe is negated. `rsp_rdata` and `rsp_err` are valid in that clock.
- R12: Chip select 0 drives `pio_cs_n` = 2'b10 and chip select 1 drives 2'b01 from setup through hold. It is 2'b11 otherwise. A strobe is never low while the chip select is 2'b11.
- R13: `pio_addr` equals the request address throughout setup, strobe and hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns period by default |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is taken on a clock where both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit register transfer |
| req_addr | input | 3 | Register address |
| req_csel | input | 1 | Chip-select choice |
| req_wdata | input | 16 | Write data |
| req_mode | input | 3 | Timing mode 0..4 (5..7 act as 0) |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Ready-line timeout, valid with rsp_done |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| pio_addr | output | 3 | Bus address lines |
| pio_cs_n | output | 2 | Active-low chip selects |
| pio_rd_n | output | 1 | Active-low read strobe |
| pio_wr_n | output | 1 | Active-low write strobe |
| pio_ready | input | 1 | Device ready, low stretches the strobe |
| pio_dout | output | 16 | Data to the bus pad |
| pio_dout_en | output | 1 | Data pad driver enable |
| pio_din | input | 16 | Data from the bus pad |

## Verification
The bound checker watches the following on every clock:
- the two strobes are never low together;
- a strobe is never low without a chip select;
- the strobe is held while ready is low and the watchdog has not expired;
- the completion pulse lasts a single cycle;
- data and address are stable under a write strobe;
- the driver is off during reads;
- the select is held after negation.

The exact phase lengths per mode need the bench's scenarios, as do the stretch arithmetic, the 1024-clock timeout, the capture edge, narrow masking and the total busy time. The bench shows the capture edge by placing the correct word on the bus only during the final strobe clock.

// File: rtl/ata_pio_pkg.sv
// Package: shared constants, state encoding and the nanosecond timing
// table of the PIO host sequencer. Assumes a clock period of at least
// 1 ns so every phase fits in PH_W bits.
package ata_pio_pkg;

    parameter int PIO_MODES = 5;
    parameter int PH_W      = 10;

    // One-hot so each strobe is a single flop gated by a stable direction bit.
    typedef enum logic [3:0] {
        ST_IDLE   = 4'b0001,
        ST_SETUP  = 4'b0010,
        ST_STROBE = 4'b0100,
        ST_POST   = 4'b1000
    } pio_state_e;

    function automatic int ns_to_clk(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int cycle_ns(input int m);
        case (m)
            0: return 600; 1: return 383; 2: return 240; 3: return 180;
            default: return 120;
        endcase
    endfunction

    function automatic int setup_ns(input int m);
        case (m)
            0: return 70; 1: return 50; 2: return 30; 3: return 30;
            default: return 25;
        endcase
    endfunction

    function automatic int width_ns(input int m);
        case (m)
            0: return 165; 1: return 125; 2: return 100; 3: return 80;
            default: return 70;
        endcase
    endfunction

    function automatic int recov_ns(input int m);
        case (m)
            3: return 70; 4: return 25;
            default: return 0;
        endcase
    endfunction

    function automatic int whold_ns(input int m);
        case (m)
            0: return 30; 1: return 20; 2: return 15; 3: return 10;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/ata_pio_timing.sv
// Module: converts a mode number into phase lengths in clocks.
// Assumes the mode register is stable for the whole access; out-of-range
// modes fall back to the slowest mode.
module ata_pio_timing
    import ata_pio_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              is_write,
    output logic [PH_W-1:0]   setup,
    output logic [PH_W-1:0]   width,
    output logic [PH_W-1:0]   hold,
    output logic [PH_W-1:0]   recov,
    output logic [PH_W-1:0]   cycle
);

    logic [PH_W-1:0] setup_tbl [PIO_MODES];
    logic [PH_W-1:0] width_tbl [PIO_MODES];
    logic [PH_W-1:0] recov_tbl [PIO_MODES];
    logic [PH_W-1:0] cycle_tbl [PIO_MODES];
    logic [PH_W-1:0] whold_tbl [PIO_MODES];
    logic [MODE_W-1:0] idx;

    // Build the per-mode clock table at elaboration.
    for (genvar m = 0; m < PIO_MODES; m++) begin : g_mode
        assign setup_tbl[m] = PH_W'(ns_to_clk(setup_ns(m), CLK_NS));
        assign width_tbl[m] = PH_W'(ns_to_clk(width_ns(m), CLK_NS));
        assign recov_tbl[m] = PH_W'(ns_to_clk(recov_ns(m), CLK_NS));
        assign cycle_tbl[m] = PH_W'(ns_to_clk(cycle_ns(m), CLK_NS));
        assign whold_tbl[m] = PH_W'(ns_to_clk(whold_ns(m), CLK_NS));
    end

    // Clamp the mode and select; hold is at least one clock.
    always_comb begin
        idx   = (mode < MODE_W'(PIO_MODES)) ? mode : '0;
        setup = setup_tbl[idx];
        width = width_tbl[idx];
        recov = recov_tbl[idx];
        cycle = cycle_tbl[idx];
        hold  = PH_W'(1);
        if (is_write && whold_tbl[idx] > PH_W'(1)) hold = whold_tbl[idx];
    end

endmodule

// File: rtl/ata_pio_ready_wd.sv
// Module: counts consecutive strobe clocks with the device ready line low
// and flags expiry on the LIMIT-th one. Assumes ready is synchronous.
module ata_pio_ready_wd #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ready,
    output logic expire
);

    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] low_cnt;

    // Count low-ready strobe clocks; clear outside the strobe or on ready.
    always_ff @(posedge clk) begin
        if (!rst_n)                low_cnt <= '0;
        else if (!active || ready) low_cnt <= '0;
        else if (!expire)          low_cnt <= low_cnt + 1'b1;
    end

    assign expire = active && !ready && (low_cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/ata_pio_host.sv
// Module: host-side PIO access sequencer. Takes one request at a time and
// steps through setup, strobe (stretched by the ready line), hold and
// recovery. Assumes pio_ready is synchronous to clk and that the pad
// tristate is built outside from pio_dout / pio_dout_en.
module ata_pio_host
    import ata_pio_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int WD_LIMIT = 1024,
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int ADDR_W   = 3,
    parameter int MODE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_csel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MODE_W-1:0] req_mode,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] pio_addr,
    output logic [1:0]        pio_cs_n,
    output logic              pio_rd_n,
    output logic              pio_wr_n,
    input  logic              pio_ready,
    output logic [DATA_W-1:0] pio_dout,
    output logic              pio_dout_en,
    input  logic [DATA_W-1:0] pio_din
);

    localparam int TOT_W = PH_W + $clog2(WD_LIMIT) + 1;

    pio_state_e        state_q;
    logic              wr_q, wide_q, csel_q, done_q, err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [MODE_W-1:0] mode_q;
    logic [PH_W-1:0]   ph_cnt, ph_inc;
    logic [TOT_W-1:0]  tot_cnt, tot_inc;
    logic [PH_W-1:0]   t_setup, t_width, t_hold, t_recov, t_cycle;
    logic              in_strobe, wd_expire, sel_on;
    logic              setup_end, width_met, post_end;

    // Keep only the low byte for 8-bit register transfers.
    function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v,
                                              input logic w);
        return w ? v : {{(DATA_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
    endfunction

    ata_pio_timing #(.CLK_NS(CLK_NS), .MODE_W(MODE_W)) u_timing (
        .mode     (mode_q),
        .is_write (wr_q),
        .setup    (t_setup),
        .width    (t_width),
        .hold     (t_hold),
        .recov    (t_recov),
        .cycle    (t_cycle)
    );

    ata_pio_ready_wd #(.LIMIT(WD_LIMIT)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (in_strobe),
        .ready  (pio_ready),
        .expire (wd_expire)
    );

    // Saturating counters and phase-end conditions.
    always_comb begin
        in_strobe = (state_q == ST_STROBE);
        ph_inc    = (ph_cnt == '1) ? ph_cnt : ph_cnt + 1'b1;
        tot_inc   = (tot_cnt == '1) ? tot_cnt : tot_cnt + 1'b1;
        setup_end = (ph_inc >= t_setup);
        width_met = (ph_inc >= t_width);
        post_end  = (ph_inc >= t_hold) && (ph_inc >= t_recov) &&
                    (tot_inc >= TOT_W'(t_cycle));
        sel_on    = (state_q == ST_SETUP) || in_strobe ||
                    ((state_q == ST_POST) && (ph_cnt < t_hold));
    end

    // Access sequencer: latch request, step phases, capture, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            wide_q  <= 1'b0;
            csel_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            mode_q  <= '0;
            ph_cnt  <= '0;
            tot_cnt <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q  <= 1'b0;
            tot_cnt <= (state_q == ST_IDLE) ? '0 : tot_inc;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_SETUP;
                        wr_q    <= req_write;
                        wide_q  <= req_wide;
                        csel_q  <= req_csel;
                        addr_q  <= req_addr;
                        wdata_q <= fit(req_wdata, req_wide);
                        mode_q  <= req_mode;
                        ph_cnt  <= '0;
                    end
                end
                ST_SETUP: begin
                    if (setup_end) begin
                        state_q <= ST_STROBE;
                        ph_cnt  <= '0;
                    end else begin
                        ph_cnt  <= ph_inc;
                    end
                end
                ST_STROBE: begin
                    if (wd_expire || (width_met && pio_ready)) begin
                        state_q <= ST_POST;
                        ph_cnt  <= '0;
                        done_q  <= 1'b1;
                        err_q   <= wd_expire;
                        rdata_q <= fit(pio_din, wide_q);
                    end else begin
                        ph_cnt  <= ph_inc;
                    end
                end
                ST_POST: begin
                    if (post_end) state_q <= ST_IDLE;
                    else          ph_cnt  <= ph_inc;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus and response outputs decoded from single state flops.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        pio_rd_n    = !(in_strobe && !wr_q);
        pio_wr_n    = !(in_strobe && wr_q);
        pio_cs_n    = sel_on ? (csel_q ? 2'b01 : 2'b10) : 2'b11;
        pio_addr    = addr_q;
        pio_dout    = wdata_q;
        pio_dout_en = wr_q && sel_on;
        rsp_done    = done_q;
        rsp_err     = err_q;
        rsp_rdata   = rdata_q;
    end

endmodule

// File: rtl/ata_pio_host_chk.sv
// Module: cycle-by-cycle protocol checker for ata_pio_host, bound below.
// Assumes it observes the top-level ports plus the watchdog expiry.
module ata_pio_host_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] pio_addr,
    input logic [1:0]        pio_cs_n,
    input logic              pio_rd_n,
    input logic              pio_wr_n,
    input logic              pio_ready,
    input logic [DATA_W-1:0] pio_dout,
    input logic              pio_dout_en,
    input logic              wd_expire
);

    logic strb;
    assign strb = !pio_rd_n || !pio_wr_n;

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pio_rd_n && !pio_wr_n));

    a_r12_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> (pio_cs_n == 2'b10 || pio_cs_n == 2'b01));

    a_r4_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !pio_ready && !wd_expire) |=> strb);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r7_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!pio_wr_n && $past(!pio_wr_n)) |->
        ($stable(pio_dout) && $stable(pio_addr) && pio_dout_en));

    a_r6_read_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        !pio_rd_n |-> !pio_dout_en);

    a_r8_busy_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> !req_ready);

    a_r7_select_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strb) && !strb) |-> (pio_cs_n != 2'b11));

endmodule

bind ata_pio_host ata_pio_host_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .pio_addr    (pio_addr),
    .pio_cs_n    (pio_cs_n),
    .pio_rd_n    (pio_rd_n),
    .pio_wr_n    (pio_wr_n),
    .pio_ready   (pio_ready),
    .pio_dout    (pio_dout),
    .pio_dout_en (pio_dout_en),
    .wd_expire   (wd_expire)
);

// File: tb/ata_pio_host_tb.sv
// Bench: directed and seeded-random accesses with a device model that
// stretches the strobe and swaps bus data to pin down the capture edge.
module ata_pio_host_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_csel = 1'b0;
    logic [2:0]  req_addr = '0, req_mode = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err, pio_rd_n, pio_wr_n, pio_dout_en;
    logic [15:0] rsp_rdata, pio_dout;
    logic [2:0]  pio_addr;
    logic [1:0]  pio_cs_n;
    logic        pio_ready = 1'b1;
    logic [15:0] pio_din = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ata_pio_host u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
        .req_csel(req_csel), .req_wdata(req_wdata), .req_mode(req_mode),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .pio_addr(pio_addr), .pio_cs_n(pio_cs_n), .pio_rd_n(pio_rd_n),
        .pio_wr_n(pio_wr_n), .pio_ready(pio_ready), .pio_dout(pio_dout),
        .pio_dout_en(pio_dout_en), .pio_din(pio_din)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected timing, from the nanosecond figures in the requirements.
    function automatic int clk10(input int ns); return (ns + 9) / 10; endfunction
    function automatic int eff(input int m); return (m < 5) ? m : 0; endfunction
    function automatic int e_setup(input int m);
        int t[5] = '{70, 50, 30, 30, 25}; return clk10(t[eff(m)]);
    endfunction
    function automatic int e_width(input int m);
        int t[5] = '{165, 125, 100, 80, 70}; return clk10(t[eff(m)]);
    endfunction
    function automatic int e_cycle(input int m);
        int t[5] = '{600, 383, 240, 180, 120}; return clk10(t[eff(m)]);
    endfunction
    function automatic int e_recov(input int m);
        int t[5] = '{0, 0, 0, 70, 25}; return clk10(t[eff(m)]);
    endfunction
    function automatic int e_hold(input int m, input bit wr);
        int t[5] = '{30, 20, 15, 10, 10};
        if (!wr) return 1;
        return (clk10(t[eff(m)]) > 1) ? clk10(t[eff(m)]) : 1;
    endfunction
    function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction

    // One access; lo = strobe cycle in which ready rises (-1: always high).
    task automatic access(input bit wr, input bit wide, input logic [2:0] addr,
                          input bit csel, input logic [15:0] data,
                          input logic [2:0] mode, input int lo);
        int m = int'(mode);
        int ew = imax(e_width(m), lo + 1);
        bit eerr = 1'b0;
        int setup = 0, width = 0, hold = 0, busy = 0, dones = 0;
        int phase = 0, j = -1, bad_bus = 0, bad_sel = 0, wrong = 0;
        logic [15:0] exp_w = wide ? data : {8'h00, data[7:0]};
        logic [15:0] rv = 16'hA5C3 ^ data;
        logic [1:0]  ecs = csel ? 2'b01 : 2'b10;
        int ebusy;
        if (lo < 0) ew = e_width(m);
        if (ew > 1024) begin ew = 1024; eerr = 1'b1; end
        ebusy = imax(e_cycle(m), e_setup(m) + ew + imax(e_hold(m, wr), e_recov(m)));
        pio_ready = (lo >= 0) ? 1'b0 : 1'b1;
        pio_din   = ~rv;
        req_write = wr; req_wide = wide; req_addr = addr; req_csel = csel;
        req_wdata = data; req_mode = mode; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~data;
        while (!req_ready) begin
            bit s_lo = wr ? !pio_wr_n : !pio_rd_n;
            busy++;
            if (wr ? !pio_rd_n : !pio_wr_n) wrong++;
            if (s_lo) begin
                phase = 1; j++; width++;
                if (j == lo) pio_ready = 1'b1;
                pio_din = (j == ew - 1) ? rv : ~rv;
            end else if (phase == 0) begin
                setup++;
            end else begin
                if (phase == 1) begin
                    chk("R11 done in first clock after strobe", rsp_done, 1);
                    chk("R5 error flag", rsp_err, eerr);
                    if (!wr) chk("R6/R9 read data",
                                 rsp_rdata, wide ? rv : {8'h00, rv[7:0]});
                end
                phase = 2;
                pio_din = ~rv;
                if (pio_cs_n != 2'b11) hold++;
            end
            if (rsp_done) dones++;
            if (phase < 2 || pio_cs_n != 2'b11) begin
                if (pio_cs_n != ecs || pio_addr != addr) bad_sel++;
                if (wr && !(pio_dout_en && pio_dout == exp_w)) bad_bus++;
            end
            if (!wr && pio_dout_en) bad_bus++;
            @(negedge clk);
        end
        chk("R2 setup clocks", setup, e_setup(m));
        chk(lo < 0 ? "R3 strobe width" : (eerr ? "R5 timeout width" : "R4 stretched width"),
            width, ew);
        chk("R3 wrong strobe clocks", wrong, 0);
        chk("R7 hold clocks", hold, e_hold(m, wr));
        chk("R8 busy clocks", busy, ebusy);
        chk("R11 done pulses", dones, 1);
        chk("R12/R13 select and address errors", bad_sel, 0);
        chk(wr ? "R7/R9 write bus errors" : "R6 driver on during read", bad_bus, 0);
        chk("R12 idle deselect", pio_cs_n, 2'b11);
        pio_ready = 1'b1;
    endtask

    task automatic idle_check(input string req);
        chk({req, " ready"}, req_ready, 1);
        chk({req, " strobes"}, {pio_rd_n, pio_wr_n}, 2'b11);
        chk({req, " selects"}, pio_cs_n, 2'b11);
        chk({req, " driver"}, pio_dout_en, 0);
        chk({req, " done"}, rsp_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h0A7A_5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle_check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        idle_check("R1 after reset");

        // Directed: every mode, both directions, no stretch.
        for (int m = 0; m < 5; m++) begin
            access(1'b1, 1'b1, 3'(m), m[0], 16'h1234 + 16'(m), 3'(m), -1);
            access(1'b0, 1'b1, 3'(m + 2), ~m[0], 16'h8E71 + 16'(m), 3'(m), -1);
        end
        access(1'b1, 1'b0, 3'd7, 1'b0, 16'hBEEF, 3'd4, -1);   // R9 narrow write
        access(1'b0, 1'b0, 3'd1, 1'b1, 16'h5A3C, 3'd2, -1);   // R9 narrow read
        access(1'b1, 1'b1, 3'd3, 1'b0, 16'h0F0F, 3'd6, -1);   // R10 mode 6 as 0
        access(1'b0, 1'b1, 3'd4, 1'b1, 16'hC001, 3'd7, -1);   // R10 mode 7 as 0
        access(1'b0, 1'b1, 3'd5, 1'b0, 16'h7777, 3'd4, 12);   // R4 stretch past width
        access(1'b1, 1'b1, 3'd6, 1'b1, 16'h2468, 3'd3, 7);    // R4 rises on last min clock
        access(1'b0, 1'b1, 3'd2, 1'b0, 16'h1357, 3'd1, 3);    // R4 early rise, no effect
        access(1'b0, 1'b1, 3'd0, 1'b1, 16'h9999, 3'd2, 5000); // R5 timeout
        access(1'b1, 1'b1, 3'd0, 1'b0, 16'h4242, 3'd4, -1);   // R5 normal after timeout
        idle_check("R1 between accesses");

        // Seeded random traffic.
        for (int k = 0; k < 40; k++) begin
            int lo = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 30)) : -1;
            access(1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom),
                   16'($urandom), 3'($urandom_range(0, 7)), lo);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule